// File: doc/BRIEF.md
# Interrupt Request Collector

This block gathers interrupt requests from five sources and presents them in one status byte with a single host interrupt line. The sources are two input-converter completion events, two output-converter events and the level interrupt of a digital I/O bank. Each converter event arrives as a one-cycle pulse. The block latches it and holds it until software reads that source's own acknowledge offset. The digital I/O request is not latched here. It follows the level from the I/O bank, which clears the request through its own logic.

The status byte has no address of its own. It shares offset 0x0F with the ordinary status byte of the second output converter. A write to 0x0F sets a control byte. While bit 5 of that byte is set, reads of 0x0F return the interrupt status. While it is clear, they return the converter status supplied on an input port. A service routine sets the bit, reads the status, and then acknowledges every set bit in one pass. It clears the bit again at the end.

Top module: `irq_status_agg`

## Requirements
- R1: After reset all latched requests are clear, the control byte is zero (so 0x0F shows the converter status), and host_irq is low unless dio_irq is high.
- R2: A one-cycle pulse on a converter event input sets its status bit from the next cycle. The bit stays set until its acknowledge read. The mapping is: input converter 0 to bit 0, input converter 1 to bit 1, output converter 0 to bit 2, output converter 1 to bit 4.
- R3: A read of offset 0x01 clears bit 0, 0x05 clears bit 1, 0x09 clears bit 2 and 0x0D clears bit 4. The bit is clear from the cycle after the read, and no other bit changes.
- R4: When a new pulse for a source arrives in the same cycle as that source's acknowledge read, the bit remains set.
- R5: Status bit 3 equals the dio_irq level in every cycle, and no read of any offset changes it.
- R6: host_irq is high exactly when any of status bits 4:0 is set.
- R7: A read of 0x0F returns the status byte while bit 5 of the last byte written to 0x0F is 1. While that bit is 0, the read returns out1_stat. Reads of any other offset return zero.
- R8: Status bits 7:5 always read as zero.
- R9: Several status bits can be set together, and acknowledging one source leaves the others set.
- R10: Reads of offsets other than the four acknowledge offsets, including 0x0F, clear no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one per cycle held |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| cnv_in_done | input | 2 | Input converter completion pulses |
| cnv_out_done | input | 2 | Output converter event pulses |
| dio_irq | input | 1 | Digital I/O interrupt level |
| out1_stat | input | 8 | Ordinary status of output converter 1 |
| host_irq | output | 1 | Combined interrupt to host |

## Verification
A request latch that fails to set, holds too long or clears on the wrong offset appears on host_irq in the cycle after the pulse or read, and in the status byte at the next read of 0x0F. A stuck or ignored select bit appears at once, as the wrong byte on a read of 0x0F. The collision case needs a pulse and an acknowledge in the same cycle. A design that gives the acknowledge priority drops the bit, and host_irq goes low one cycle later.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int N_LATCH   = 4;
  localparam int SEL_BIT   = 5;
  localparam logic [ADDR_W-1:0] SHARED_OFS = 4'hF;

  // acknowledge offset of latched source idx: 0x1, 0x5, 0x9, 0xD
  function automatic logic [ADDR_W-1:0] ack_offset(input int idx);
    return ADDR_W'(4 * idx + 1);
  endfunction

  // place latched flags and the dio level into the status byte
  function automatic logic [DATA_W-1:0] pack_status(input logic [N_LATCH-1:0] f,
                                                     input logic dio);
    logic [DATA_W-1:0] s;
    s    = '0;
    s[0] = f[0];
    s[1] = f[1];
    s[2] = f[2];
    s[3] = dio;
    s[4] = f[3];
    return s;
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (ack_i) flag_o <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !ack_i) |=> flag_o);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (wr_i) ctrl_o <= wdata_i;
  end

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] ext_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == SHARED_OFS) rdata_o = sel_i ? status_i : ext_i;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        cnv_in_done,
  input  logic [1:0]        cnv_out_done,
  input  logic              dio_irq,
  input  logic [DATA_W-1:0] out1_stat,
  output logic              host_irq
);
  logic [N_LATCH-1:0] src_pulse, ack_hit, flags;
  logic [DATA_W-1:0]  ctrl, status;
  logic               ctrl_wr, status_sel;

  assign src_pulse  = {cnv_out_done[1], cnv_out_done[0], cnv_in_done[1], cnv_in_done[0]};
  assign ctrl_wr    = bus_wr && (bus_addr == SHARED_OFS);
  assign status_sel = ctrl[SEL_BIT];

  for (genvar i = 0; i < N_LATCH; i++) begin : g_src
    assign ack_hit[i] = bus_rd && (bus_addr == ack_offset(i));
    irq_req_latch u_latch (
      .clk(clk), .rst_n(rst_n), .set_i(src_pulse[i]),
      .ack_i(ack_hit[i]), .flag_o(flags[i])
    );
  end

  irq_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .wdata_i(bus_wdata), .ctrl_o(ctrl)
  );

  assign status   = pack_status(flags, dio_irq);
  assign host_irq = |status[4:0];

  irq_read_mux u_mux (
    .addr_i(bus_addr), .sel_i(status_sel), .status_i(status),
    .ext_i(out1_stat), .rdata_o(bus_rdata)
  );

  // R6: the line is high only with a latched flag or the dio level behind it
  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> ((|flags) || dio_irq));
  // R6: a pulse always raises the line in the next cycle
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> host_irq);
  // R8: upper status bits never show on the bus
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SHARED_OFS && status_sel) |-> bus_rdata[7:5] == 3'b000);
  // R10: a read of a non-acknowledge offset leaves every flag set
  p_no_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ack_hit == '0) |=> ((flags & $past(flags)) == $past(flags)));
  // R7: other offsets read as zero
  p_other_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != SHARED_OFS) |-> bus_rdata == '0);
endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, out1_stat = 8'hA5;
  logic [1:0] cnv_in_done = 0, cnv_out_done = 0;
  logic dio_irq = 0, host_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg u_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnv_in_done(cnv_in_done), .cnv_out_done(cnv_out_done),
    .dio_irq(dio_irq), .out1_stat(out1_stat), .host_irq(host_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = 0;
  endtask

  // source index 0..3 -> in0, in1, out0, out1
  task automatic pulse(int s);
    @(negedge clk);
    if (s < 2) cnv_in_done[s] = 1; else cnv_out_done[s-2] = 1;
    @(negedge clk); cnv_in_done = 0; cnv_out_done = 0;
  endtask

  function automatic logic [3:0] ack_of(int s); return 4'(4*s + 1); endfunction
  function automatic logic [7:0] bit_of(int s); return (s == 3) ? 8'h10 : 8'(1 << s); endfunction

  task automatic t_reset;
    logic [7:0] d;
    rd(4'hF, d); check("R1 shared offset after reset", d, 8'hA5);
    check("R1 host_irq after reset", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_latch_ack;
    logic [7:0] d;
    wr(4'hF, 8'h20);
    for (int s = 0; s < 4; s++) begin
      pulse(s);
      repeat (3) @(negedge clk);
      rd(4'hF, d); check("R2 latched bit held", d, bit_of(s));
      check("R6 host_irq with latched bit", {7'b0, host_irq}, 8'h01);
      rd(4'hF, d); check("R10 read of 0x0F keeps bit", d, bit_of(s));
      rd(ack_of(s), d); check("R7 ack offset reads zero", d, 8'h00);
      rd(4'hF, d); check("R3 ack clears bit", d, 8'h00);
      check("R6 host_irq low after ack", {7'b0, host_irq}, 8'h00);
    end
  endtask

  task automatic t_collide;
    logic [7:0] d;
    pulse(1);
    @(negedge clk); cnv_in_done[1] = 1; bus_rd = 1; bus_addr = ack_of(1);
    @(negedge clk); cnv_in_done = 0; bus_rd = 0; bus_addr = 0;
    rd(4'hF, d); check("R4 pulse with ack keeps bit", d, 8'h02);
    rd(ack_of(1), d); rd(4'hF, d); check("R4 later ack clears", d, 8'h00);
  endtask

  task automatic t_multi;
    logic [7:0] d;
    @(negedge clk); cnv_in_done = 2'b11; cnv_out_done = 2'b11;
    @(negedge clk); cnv_in_done = 0; cnv_out_done = 0;
    rd(4'hF, d); check("R9 all latched", d, 8'h17);
    rd(ack_of(2), d); rd(4'hF, d); check("R9 others survive ack", d, 8'h13);
    for (int a = 0; a < 16; a++)
      if (a != 1 && a != 5 && a != 9 && a != 13) rd(4'(a), d);
    rd(4'hF, d); check("R10 non-ack reads clear nothing", d, 8'h13);
    rd(ack_of(0), d); rd(ack_of(1), d); rd(ack_of(3), d);
    rd(4'hF, d); check("R3 all cleared", d, 8'h00);
  endtask

  task automatic t_dio;
    logic [7:0] d;
    @(negedge clk); dio_irq = 1;
    #1 check("R6 host_irq follows dio", {7'b0, host_irq}, 8'h01);
    for (int s = 0; s < 4; s++) rd(ack_of(s), d);
    rd(4'hF, d); check("R5 dio bit not cleared by reads", d, 8'h08);
    @(negedge clk); dio_irq = 0;
    rd(4'hF, d); check("R5 dio bit follows level", d, 8'h00);
    check("R6 host_irq low", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_mux;
    logic [7:0] d;
    pulse(3);
    wr(4'hF, 8'hDF);
    out1_stat = 8'h3C;
    rd(4'hF, d); check("R7 select clear shows converter status", d, 8'h3C);
    check("R6 host_irq independent of select", {7'b0, host_irq}, 8'h01);
    wr(4'hF, 8'hFF);
    rd(4'hF, d); check("R8 upper bits zero", d, 8'h10);
    rd(ack_of(3), d);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk); rst_n = 1;
        t_reset; t_latch_ack; t_collide; t_multi; t_dio; t_mux;
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule